// File: doc/BRIEF.md
# Coherent Late-Write Staging Buffer with Byte Merge

This block sits between the write side of a burst memory and its storage array. Each accepted write carries one burst address, four data beats and an active-low enable for every 9-bit byte of every beat. The write is not put into the array at once. It goes into a small first-in first-out staging buffer and reaches the array only when a later write pushes it out. With the default depth of two, a write is committed on the third write command. Reads must still see the newest data. A lookup therefore compares its address against every staged entry. For each byte it takes the newest enabled copy, and where no staged entry enabled that byte it falls back to the array.

Each address holds one whole burst of four beats. Beat b uses bits `[b*WORD_W +: WORD_W]` of a data bus. Byte j of beat b uses bits `[b*WORD_W + j*9 +: 9]`, and its enable is bit `b*NB + j`, where NB = WORD_W/9 (4 for a 36-bit word, 2 for an 18-bit word). A small reset-cleared array model is built in so that the whole path can be observed at the ports. Every array write is also shown on the commit outputs.

Top module: `qwb_top`

## Requirements
- R1: After reset the staging buffer is empty, `rd_valid` and `commit_valid` are low, and a read of any address returns all zeros with `rd_hit` low.
- R2: `rd_valid` is high in exactly the cycle after a cycle with `rd_req` high. `rd_data` and `rd_hit` change only in that case and otherwise hold their values.
- R3: A write with `wr_req` high is staged. It reaches the array only when a push happens while DEPTH entries are already staged. With DEPTH=2 this is the third write, and `commit_valid` is high in that cycle.
- R4: A read of either of the two most recently staged addresses returns the staged bytes rather than the array contents. A read of the address written in the previous cycle returns each of its four enabled beats unchanged, and `rd_hit` is high.
- R5: When two staged entries share an address, the bytes enabled in the newer entry override those of the older entry.
- R6: Enables are active low and independent per byte per beat, at bit `b*NB + j`. A byte whose enable is high keeps its earlier content, taken from an older staged entry or from the array.
- R7: A write whose enables are all high still takes a buffer slot. When it is committed its `commit_mask` is all zero, and it changes no stored byte.
- R8: With `wr_req` low nothing is staged or committed, and `commit_valid` is low.
- R9: A read that matches no staged entry returns the array word unchanged, with `rd_hit` low.
- R10: Entries are committed oldest first. `commit_addr` is the oldest staged address, and `commit_mask` is the inverse of that entry's enables.
- R11: When a read and a write occur in the same cycle, the read returns the contents as they stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write command for this cycle |
| wr_addr | input | ADDR_W | Burst address of the write |
| wr_data | input | 4*WORD_W | Four write beats, beat 0 in the low bits |
| wr_be_n | input | 4*NB | Active-low byte enables, bit b*NB+j |
| rd_req | input | 1 | Read lookup for this cycle |
| rd_addr | input | ADDR_W | Burst address of the lookup |
| rd_valid | output | 1 | Lookup result valid, one cycle after rd_req |
| rd_data | output | 4*WORD_W | Four merged read beats |
| rd_hit | output | 1 | Lookup matched at least one staged entry |
| commit_valid | output | 1 | Oldest entry is written to the array this cycle |
| commit_addr | output | ADDR_W | Address being committed |
| commit_mask | output | 4*NB | Active-high byte mask of the commit |

## Verification
The bench aims at reads that fall on the two staged addresses just before and after a commit moves one of them into the array. A design that commits too early or too late returns stale or premature bytes there. It also stages two partial writes to the same address with overlapping and disjoint enables. A wrong merge order would let older bytes win, and dropping the fallback would return zeros instead of array content. Aborted writes, cycles with no write, and a read issued in the same cycle as a write to the same address are all checked. A design that committed a zero-mask write as a full write would corrupt memory. One that counted idle cycles as writes would commit early. One that let a same-cycle write bypass would return the new data. A long random run over a few addresses compares every read and commit against a queue-based model.

// File: rtl/qwb_pkg.sv
package qwb_pkg;
  localparam int BYTE_W = 9;
  localparam int BURST  = 4;

  function automatic int bytes_per_word(input int word_w);
    return word_w / BYTE_W;
  endfunction
endpackage

// File: rtl/qwb_slot_fifo.sv
module qwb_slot_fifo
  import qwb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 36,
  parameter int DEPTH  = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              push,
  input  logic [ADDR_W-1:0]                 push_addr,
  input  logic [BURST*WORD_W-1:0]           push_data,
  input  logic [BURST*(WORD_W/BYTE_W)-1:0]  push_mask,
  output logic [DEPTH-1:0]                  slot_vld,
  output logic [DEPTH-1:0][ADDR_W-1:0]      slot_addr,
  output logic [DEPTH-1:0][BURST*WORD_W-1:0] slot_data,
  output logic [DEPTH-1:0][BURST*(WORD_W/BYTE_W)-1:0] slot_mask,
  output logic                              pop_valid,
  output logic [ADDR_W-1:0]                 pop_addr,
  output logic [BURST*(WORD_W/BYTE_W)-1:0]  pop_mask,
  output logic [BURST*WORD_W-1:0]           pop_data
);
  localparam int DATA_W = BURST * WORD_W;
  localparam int MASK_W = BURST * (WORD_W / BYTE_W);
  localparam int OCC_W  = $clog2(DEPTH + 1);

  // Slot 0 holds the newest entry, slot DEPTH-1 the oldest.
  logic [DEPTH-1:0]              vld_nxt;
  logic [DEPTH-1:0][ADDR_W-1:0]  addr_nxt;
  logic [DEPTH-1:0][DATA_W-1:0]  data_nxt;
  logic [DEPTH-1:0][MASK_W-1:0]  mask_nxt;
  logic [OCC_W-1:0]              occ_q, occ_nxt;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i == 0) begin : g_head
        always_comb begin
          vld_nxt[i]  = 1'b1;
          addr_nxt[i] = push_addr;
          data_nxt[i] = push_data;
          mask_nxt[i] = push_mask;
        end
      end else begin : g_body
        always_comb begin
          vld_nxt[i]  = slot_vld[i-1];
          addr_nxt[i] = slot_addr[i-1];
          data_nxt[i] = slot_data[i-1];
          mask_nxt[i] = slot_mask[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          slot_vld[i] <= 1'b0;
        end else if (push) begin
          slot_vld[i] <= vld_nxt[i];
        end
      end

      always_ff @(posedge clk) begin
        if (push) begin
          slot_addr[i] <= addr_nxt[i];
          slot_data[i] <= data_nxt[i];
          slot_mask[i] <= mask_nxt[i];
        end
      end
    end
  endgenerate

  always_comb begin
    occ_nxt = occ_q;
    if (push && (occ_q != OCC_W'(DEPTH))) begin
      occ_nxt = occ_q + OCC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else begin
      occ_q <= occ_nxt;
    end
  end

  assign pop_valid = push & slot_vld[DEPTH-1];
  assign pop_addr  = slot_addr[DEPTH-1];
  assign pop_mask  = slot_mask[DEPTH-1];
  assign pop_data  = slot_data[DEPTH-1];

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(DEPTH)); // R3
  AST_POP_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> (occ_q == OCC_W'(DEPTH))); // R3
  AST_OLDEST_VALID_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == OCC_W'(DEPTH)) |-> slot_vld[DEPTH-1]); // R10
endmodule

// File: rtl/qwb_fwd_merge.sv
module qwb_fwd_merge
  import qwb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 36,
  parameter int DEPTH  = 2
) (
  input  logic [ADDR_W-1:0]                        lookup_addr,
  input  logic [DEPTH-1:0]                         slot_vld,
  input  logic [DEPTH-1:0][ADDR_W-1:0]             slot_addr,
  input  logic [DEPTH-1:0][BURST*WORD_W-1:0]       slot_data,
  input  logic [DEPTH-1:0][BURST*(WORD_W/BYTE_W)-1:0] slot_mask,
  input  logic [BURST*WORD_W-1:0]                  arr_data,
  output logic [BURST*WORD_W-1:0]                  merged,
  output logic                                     hit
);
  localparam int MASK_W = BURST * (WORD_W / BYTE_W);

  logic [DEPTH-1:0] match;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      match[i] = slot_vld[i] && (slot_addr[i] == lookup_addr);
    end
  end

  // Oldest slot first, so that newer enabled bytes overwrite older ones.
  always_comb begin
    merged = arr_data;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        for (int k = 0; k < MASK_W; k++) begin
          if (slot_mask[i][k]) begin
            merged[k*BYTE_W +: BYTE_W] = slot_data[i][k*BYTE_W +: BYTE_W];
          end
        end
      end
    end
  end

  assign hit = |match;
endmodule

// File: rtl/qwb_array.sv
module qwb_array
  import qwb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 36
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [ADDR_W-1:0]                 waddr,
  input  logic [BURST*WORD_W-1:0]           wdata,
  input  logic [BURST*(WORD_W/BYTE_W)-1:0]  wmask,
  input  logic [ADDR_W-1:0]                 raddr,
  output logic [BURST*WORD_W-1:0]           rdata
);
  localparam int DATA_W = BURST * WORD_W;
  localparam int MASK_W = BURST * (WORD_W / BYTE_W);
  localparam int WORDS  = 1 << ADDR_W;

  logic [WORDS-1:0][DATA_W-1:0] store_q;

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic sel;
      assign sel = we && (waddr == ADDR_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          store_q[w] <= '0;
        end else if (sel) begin
          for (int k = 0; k < MASK_W; k++) begin
            if (wmask[k]) begin
              store_q[w][k*BYTE_W +: BYTE_W] <= wdata[k*BYTE_W +: BYTE_W];
            end
          end
        end
      end
    end
  endgenerate

  assign rdata = store_q[raddr];
endmodule

// File: rtl/qwb_top.sv
module qwb_top
  import qwb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 36,
  parameter int DEPTH  = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_req,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [BURST*WORD_W-1:0]           wr_data,
  input  logic [BURST*(WORD_W/BYTE_W)-1:0]  wr_be_n,
  input  logic                              rd_req,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic                              rd_valid,
  output logic [BURST*WORD_W-1:0]           rd_data,
  output logic                              rd_hit,
  output logic                              commit_valid,
  output logic [ADDR_W-1:0]                 commit_addr,
  output logic [BURST*(WORD_W/BYTE_W)-1:0]  commit_mask
);
  localparam int DATA_W = BURST * WORD_W;
  localparam int MASK_W = BURST * (WORD_W / BYTE_W);

  logic [DEPTH-1:0]              slot_vld;
  logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr;
  logic [DEPTH-1:0][DATA_W-1:0]  slot_data;
  logic [DEPTH-1:0][MASK_W-1:0]  slot_mask;
  logic                          pop_valid;
  logic [ADDR_W-1:0]             pop_addr;
  logic [MASK_W-1:0]             pop_mask;
  logic [DATA_W-1:0]             pop_data;
  logic [DATA_W-1:0]             arr_rdata;
  logic [DATA_W-1:0]             lk_merged;
  logic                          lk_hit;

  logic                          rd_valid_d;
  logic [DATA_W-1:0]             rd_data_d;
  logic                          rd_hit_d;

  qwb_slot_fifo #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_req),
    .push_addr (wr_addr),
    .push_data (wr_data),
    .push_mask (~wr_be_n),
    .slot_vld  (slot_vld),
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .slot_mask (slot_mask),
    .pop_valid (pop_valid),
    .pop_addr  (pop_addr),
    .pop_mask  (pop_mask),
    .pop_data  (pop_data)
  );

  qwb_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pop_valid),
    .waddr (pop_addr),
    .wdata (pop_data),
    .wmask (pop_mask),
    .raddr (rd_addr),
    .rdata (arr_rdata)
  );

  qwb_fwd_merge #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_merge (
    .lookup_addr (rd_addr),
    .slot_vld    (slot_vld),
    .slot_addr   (slot_addr),
    .slot_data   (slot_data),
    .slot_mask   (slot_mask),
    .arr_data    (arr_rdata),
    .merged      (lk_merged),
    .hit         (lk_hit)
  );

  always_comb begin
    rd_valid_d = rd_req;
    rd_data_d  = rd_data;
    rd_hit_d   = rd_hit;
    if (rd_req) begin
      rd_data_d = lk_merged;
      rd_hit_d  = lk_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_hit   <= 1'b0;
    end else begin
      rd_valid <= rd_valid_d;
      rd_data  <= rd_data_d;
      rd_hit   <= rd_hit_d;
    end
  end

  assign commit_valid = pop_valid;
  assign commit_addr  = pop_addr;
  assign commit_mask  = pop_mask;

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid); // R2
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> ($stable(rd_data) && $stable(rd_hit))); // R2
  AST_COMMIT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> wr_req); // R8
  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_merged == arr_rdata)); // R9
endmodule

// File: tb/qwb_top_tb.sv
module qwb_top_tb_top;
  localparam int AW = 4;
  localparam int WW = 36;
  localparam int NB = WW / 9;
  localparam int DW = 4 * WW;
  localparam int MW = 4 * NB;
  localparam int DEP = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_req;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [MW-1:0] wr_be_n;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          rd_hit;
  logic          commit_valid;
  logic [AW-1:0] commit_addr;
  logic [MW-1:0] commit_mask;

  always #4 clk = ~clk;

  qwb_top #(.ADDR_W(AW), .WORD_W(WW), .DEPTH(DEP)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be_n(wr_be_n),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_hit(rd_hit),
    .commit_valid(commit_valid), .commit_addr(commit_addr), .commit_mask(commit_mask)
  );

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [MW-1:0] m;
  } ent_t;

  ent_t          q[$];
  logic [DW-1:0] mem_m [16];
  int            n_chk = 0;
  int            n_err = 0;
  bit            done = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_read(input logic [AW-1:0] a, output bit h);
    logic [DW-1:0] v;
    v = mem_m[a];
    h = 0;
    foreach (q[i]) begin
      if (q[i].a == a) begin
        h = 1;
        for (int k = 0; k < MW; k++) if (q[i].m[k]) v[k*9 +: 9] = q[i].d[k*9 +: 9];
      end
    end
    return v;
  endfunction

  // One clock: drive at negedge, check commit, update model at posedge, check read.
  task automatic cycle(input bit w, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input logic [MW-1:0] wbn, input bit r, input logic [AW-1:0] ra,
                       input string tag);
    bit            exp_cv;
    bit            exp_h;
    logic [DW-1:0] exp_d;
    wr_req = w; wr_addr = wa; wr_data = wd; wr_be_n = wbn;
    rd_req = r; rd_addr = ra;
    #1;
    exp_cv = w && (q.size() == DEP);
    chk({tag, " R3/R8 commit_valid"}, DW'(commit_valid), DW'(exp_cv));
    if (exp_cv) begin
      chk({tag, " R10 commit_addr"}, DW'(commit_addr), DW'(q[0].a));
      chk({tag, " R10 commit_mask"}, DW'(commit_mask), DW'(q[0].m));
    end
    @(posedge clk);
    exp_d = ref_read(ra, exp_h);
    if (w) begin
      if (q.size() == DEP) begin
        ent_t e;
        e = q.pop_front();
        for (int k = 0; k < MW; k++) if (e.m[k]) mem_m[e.a][k*9 +: 9] = e.d[k*9 +: 9];
      end
      q.push_back('{a: wa, d: wd, m: ~wbn});
    end
    @(negedge clk);
    chk({tag, " R2 rd_valid"}, DW'(rd_valid), DW'(r));
    if (r) begin
      chk({tag, " data"}, rd_data, exp_d);
      chk({tag, " R9 rd_hit"}, DW'(rd_hit), DW'(exp_h));
    end
  endtask

  task automatic idle(input string tag);
    cycle(0, '0, '0, '1, 0, '0, tag);
  endtask

  function automatic logic [DW-1:0] pat(input int seed);
    logic [DW-1:0] v;
    for (int k = 0; k < MW; k++) v[k*9 +: 9] = 9'((seed * 37 + k * 11 + 5) & 9'h1FF);
    return v;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [MW-1:0] m_lo;
    rst_n = 1'b0;
    wr_req = 0; wr_addr = '0; wr_data = '0; wr_be_n = '1; rd_req = 0; rd_addr = '0;
    for (int i = 0; i < 16; i++) mem_m[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 rd_valid at reset", DW'(rd_valid), '0);
    chk("R1 commit_valid at reset", DW'(commit_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    cycle(0, '0, '0, '1, 1, 4'd5, "R1 empty read");

    // R4: read the address written just before; then the older of two staged.
    cycle(1, 4'd3, pat(1), '0, 0, '0, "R4 write A");
    cycle(0, '0, '0, '1, 1, 4'd3, "R4 read newest");
    cycle(1, 4'd7, pat(2), '0, 1, 4'd3, "R4 read older");
    cycle(0, '0, '0, '1, 1, 4'd7, "R4 read B");

    // R3 R10: third write commits address 3; data then comes from the array.
    cycle(1, 4'd9, pat(3), '0, 1, 4'd3, "R3 third write");
    cycle(0, '0, '0, '1, 1, 4'd3, "R9 read committed");

    // R8: idle cycles with wr_req low stage nothing.
    cycle(0, 4'd3, pat(99), '0, 1, 4'd3, "R8 no write");
    idle("R8 idle");

    // R5 R6: two partial writes to one address, low bytes then overlapping.
    m_lo = '0;
    for (int b = 0; b < 4; b++) m_lo[b*NB +: 2] = 2'b11;
    cycle(1, 4'd3, pat(4), ~m_lo, 0, '0, "R6 partial low");
    cycle(1, 4'd3, pat(5), {MW{1'b1}} ^ MW'(16'h0F0F), 1, 4'd3, "R6 merge array");
    cycle(0, '0, '0, '1, 1, 4'd3, "R5 newer wins");

    // R7: aborted write takes a slot but its commit changes nothing.
    cycle(1, 4'd7, pat(6), '1, 1, 4'd7, "R7 abort staged");
    cycle(0, '0, '0, '1, 1, 4'd7, "R7 abort read");
    cycle(1, 4'd1, pat(7), '0, 0, '0, "R10 push 1");
    cycle(1, 4'd2, pat(8), '0, 1, 4'd7, "R7 abort commit");

    // R11: read and write of the same address in one cycle.
    cycle(1, 4'd2, pat(9), '0, 1, 4'd2, "R11 same cycle");
    cycle(0, '0, '0, '1, 1, 4'd2, "R11 after");

    // Random stress over a small address set.
    for (int n = 0; n < 400; n++) begin
      cycle(1'($urandom_range(0, 1)), 4'($urandom_range(0, 3)), pat(int'($urandom)),
            MW'($urandom), 1'($urandom_range(0, 1)), 4'($urandom_range(0, 3)),
            "R4/R5/R6 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule